// File: doc/BRIEF.md
# Legacy Interrupt Request and Acknowledge Path

This block captures interrupt requests on eight lines and resolves them by fixed priority. It raises a single interrupt output towards the processor and answers the processor's two-pulse, active-low acknowledge with an 8-bit vector. Each line is set to edge or level sensing by its own bit of `edge_mode`. Pending requests sit in a request register. Granted ones move into an in-service register, and an end-of-interrupt strobe clears them again. Lines already in service keep requests of equal or lower priority from reaching the processor.

A request must still be pending when the first acknowledge pulse falls. If it has gone by then, the controller still completes the handshake, but it answers with the vector of the lowest-priority line. This spurious answer sets no in-service bit and leaves request bit 7 clear.

The handshake runs through four named states:
- `ST_IDLE`: the interrupt output may be high.
- `ST_ACK1`: the first pulse is low and the selection is frozen.
- `ST_GAP`: the wait between the two pulses.
- `ST_ACK2`: the second pulse is low and the vector is driven.

The transitions are:
- Idle to first-pulse, on a falling acknowledge edge. This edge is the take point.
- First-pulse to gap, on a rising edge.
- Gap to second-pulse, on a falling edge.
- Second-pulse to idle, on a rising edge.

The acknowledge input is taken as synchronous to `clk`. An edge counts on the first clock that sees the new level.

Top module: `irq_ack_ctrl`

## Requirements
- R1: While `rst_n` is low and right after reset, `int_out`, `vec_valid`, `vec_out`, `irr_out` and `isr_out` are all zero, and the handshake is in `ST_IDLE`.
- R2: For a line with its `edge_mode` bit set to 1, a rising edge sets its `irr_out` bit on the next clock. The bit clears on the clock after the line goes low, if no acknowledge has taken it first.
- R3: For a line with its `edge_mode` bit set to 0, its `irr_out` bit equals the line's value one clock earlier.
- R4: In `ST_IDLE`, `int_out` is 1 exactly when an unmasked pending request exists. Among several such requests, line 0 has the highest priority and line 7 the lowest.
- R5: A set `isr_out` bit i masks pending requests on lines i through 7 from `int_out` and from selection.
- R6: The clock that sees the first acknowledge falling edge in `ST_IDLE` freezes the winning line and sets its `isr_out` bit. On that clock, the winner's `irr_out` bit is cleared only if the line is edge-sensed. At most one `isr_out` bit is set per clock.
- R7: While the second acknowledge pulse is low (`ST_ACK2`), `vec_valid` is 1 and `vec_out` is `{vec_base[4:0], index[2:0]}`. At all other times `vec_out` is zero.
- R8: If no unmasked request is pending at the first acknowledge falling edge, the vector index is 7, no `isr_out` bit is set, and `irr_out` bit 7 is not set by it.
- R9: An `eoi` pulse clears only the highest-priority (lowest-index) set `isr_out` bit.
- R10: `int_out` is 0 in every state other than `ST_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_in | input | 8 | Request lines; index 0 has the highest priority |
| edge_mode | input | 8 | Per line: 1 = edge-sensed, 0 = level-sensed |
| vec_base | input | 5 | Upper five bits of the returned vector |
| ack_n | input | 1 | Active-low acknowledge from the processor; two pulses per handshake |
| eoi | input | 1 | One-clock end-of-interrupt strobe |
| int_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector, valid during the second acknowledge pulse |
| vec_valid | output | 1 | High while `vec_out` carries a vector |
| irr_out | output | 8 | Request register |
| isr_out | output | 8 | In-service register |

## Verification
The bench withdraws an edge request before the acknowledge arrives and expects the index-7 default vector with no in-service or request bit 7. A design that honoured the stale request would return the original line's vector instead, and one that treated the withdrawal as a real request would mark line 7 in service. The bench also raises a second edge on a line that is already in service and expects it to stay masked. A resolver that masked only strictly lower priorities would raise the interrupt again. Nested in-service bits followed by end-of-interrupt strobes show whether the clear picks the highest priority; clearing the wrong bit reorders the later grants. A level line that is still high after its end-of-interrupt must raise the interrupt again, which a design clearing level requests at the take point would miss.

// File: rtl/irq_pkg.sv
package irq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACK1 = 2'd1,
        ST_GAP  = 2'd2,
        ST_ACK2 = 2'd3
    } ack_state_t;
endpackage

// File: rtl/irq_req_capture.sv
module irq_req_capture #(
    parameter int N_IRQ = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IRQ-1:0] req_in,
    input  logic [N_IRQ-1:0] edge_mode,
    input  logic [N_IRQ-1:0] take_clr,
    output logic [N_IRQ-1:0] irr
);
    logic [N_IRQ-1:0] req_prev;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_prev <= '0;
        end else begin
            req_prev <= req_in;
        end
    end

    for (genvar g = 0; g < N_IRQ; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                irr[g] <= 1'b0;
            end else if (edge_mode[g]) begin
                // an edge request persists only while the line stays high
                irr[g] <= (irr[g] | (req_in[g] & ~req_prev[g]))
                          & req_in[g] & ~take_clr[g];
            end else begin
                irr[g] <= req_in[g];
            end
        end
    end
endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver #(
    parameter int N_IRQ = 8,
    localparam int IDX_W = $clog2(N_IRQ)
) (
    input  logic [N_IRQ-1:0] irr,
    input  logic [N_IRQ-1:0] isr,
    output logic             win_valid,
    output logic [IDX_W-1:0] win_idx
);
    int ceiling;

    always_comb begin
        ceiling = N_IRQ;
        for (int i = N_IRQ - 1; i >= 0; i--) begin
            if (isr[i]) ceiling = i;
        end
        win_valid = 1'b0;
        win_idx   = '0;
        for (int i = N_IRQ - 1; i >= 0; i--) begin
            if (irr[i] && (i < ceiling)) begin
                win_valid = 1'b1;
                win_idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm
    import irq_pkg::*;
#(
    parameter int N_IRQ = 8,
    localparam int IDX_W = $clog2(N_IRQ),
    localparam logic [IDX_W-1:0] SPUR_IDX = IDX_W'(N_IRQ - 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack_n,
    input  logic             eoi,
    input  logic             win_valid,
    input  logic [IDX_W-1:0] win_idx,
    input  logic [N_IRQ-1:0] edge_mode,
    output ack_state_t       state,
    output logic [IDX_W-1:0] sel_idx,
    output logic [N_IRQ-1:0] isr,
    output logic [N_IRQ-1:0] take_clr
);
    ack_state_t       state_nx;
    logic             ack_q;
    logic             ack_fall;
    logic             ack_rise;
    logic             take;
    logic [N_IRQ-1:0] set_mask;
    logic [N_IRQ-1:0] eoi_clr;

    assign ack_fall = ack_q & ~ack_n;
    assign ack_rise = ~ack_q & ack_n;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (ack_fall) state_nx = ST_ACK1;
            ST_ACK1: if (ack_rise) state_nx = ST_GAP;
            ST_GAP:  if (ack_fall) state_nx = ST_ACK2;
            ST_ACK2: if (ack_rise) state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            ack_q <= 1'b1;
        end else begin
            state <= state_nx;
            ack_q <= ack_n;
        end
    end

    always_comb begin
        take     = (state == ST_IDLE) && ack_fall;
        set_mask = '0;
        if (take && win_valid) set_mask = N_IRQ'(1) << win_idx;
        take_clr = set_mask & edge_mode;
        eoi_clr  = '0;
        if (eoi) begin
            for (int i = N_IRQ - 1; i >= 0; i--) begin
                if (isr[i]) eoi_clr = N_IRQ'(1) << i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr     <= '0;
            sel_idx <= '0;
        end else begin
            isr <= (isr & ~eoi_clr) | set_mask;
            if (take) sel_idx <= win_valid ? win_idx : SPUR_IDX;
        end
    end
endmodule

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl
    import irq_pkg::*;
#(
    parameter int N_IRQ = 8,
    parameter int VEC_W = 8,
    localparam int IDX_W = $clog2(N_IRQ),
    localparam int BASE_W = VEC_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IRQ-1:0]  req_in,
    input  logic [N_IRQ-1:0]  edge_mode,
    input  logic [BASE_W-1:0] vec_base,
    input  logic              ack_n,
    input  logic              eoi,
    output logic              int_out,
    output logic [VEC_W-1:0]  vec_out,
    output logic              vec_valid,
    output logic [N_IRQ-1:0]  irr_out,
    output logic [N_IRQ-1:0]  isr_out
);
    ack_state_t       state;
    logic [N_IRQ-1:0] irr;
    logic [N_IRQ-1:0] isr;
    logic [N_IRQ-1:0] take_clr;
    logic             win_valid;
    logic [IDX_W-1:0] win_idx;
    logic [IDX_W-1:0] sel_idx;

    irq_req_capture #(.N_IRQ(N_IRQ)) u_cap (
        .clk(clk), .rst_n(rst_n), .req_in(req_in), .edge_mode(edge_mode),
        .take_clr(take_clr), .irr(irr)
    );

    irq_prio_resolver #(.N_IRQ(N_IRQ)) u_res (
        .irr(irr), .isr(isr), .win_valid(win_valid), .win_idx(win_idx)
    );

    irq_ack_fsm #(.N_IRQ(N_IRQ)) u_fsm (
        .clk(clk), .rst_n(rst_n), .ack_n(ack_n), .eoi(eoi),
        .win_valid(win_valid), .win_idx(win_idx), .edge_mode(edge_mode),
        .state(state), .sel_idx(sel_idx), .isr(isr), .take_clr(take_clr)
    );

    always_comb begin
        int_out   = (state == ST_IDLE) && win_valid;
        vec_valid = (state == ST_ACK2);
        vec_out   = vec_valid ? {vec_base, sel_idx} : '0;
        irr_out   = irr;
        isr_out   = isr;
    end
endmodule

// File: rtl/irq_ack_ctrl_chk.sv
module irq_ack_ctrl_chk #(
    parameter int N_IRQ = 8,
    parameter int VEC_W = 8,
    localparam int IDX_W = $clog2(N_IRQ),
    localparam int BASE_W = VEC_W - IDX_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ack_n,
    input logic              eoi,
    input logic [BASE_W-1:0] vec_base,
    input logic              int_out,
    input logic [VEC_W-1:0]  vec_out,
    input logic              vec_valid,
    input logic [N_IRQ-1:0]  isr_out
);
    AST_VEC_IN_SECOND_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> !$past(ack_n)); // R7
    AST_VEC_CARRIES_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (vec_out[VEC_W-1:IDX_W] == vec_base)); // R7
    AST_VEC_ZERO_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_valid |-> (vec_out == '0)); // R7
    AST_INT_QUIET_IN_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> !int_out); // R10
    AST_ONE_GRANT_PER_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(isr_out & ~$past(isr_out)) <= 1)); // R6
    AST_EOI_DROPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && (isr_out != '0) && ack_n && $past(ack_n))
        |=> ($countones(isr_out) == $countones($past(isr_out)) - 1)); // R9
endmodule

bind irq_ack_ctrl irq_ack_ctrl_chk #(.N_IRQ(N_IRQ), .VEC_W(VEC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ack_n(ack_n), .eoi(eoi), .vec_base(vec_base),
    .int_out(int_out), .vec_out(vec_out), .vec_valid(vec_valid), .isr_out(isr_out)
);

// File: tb/irq_ack_ctrl_test.sv
module irq_ack_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req_in = '0;
    logic [7:0] edge_mode = 8'b0011_1111;
    logic [4:0] vec_base = 5'b10101;
    logic       ack_n = 1'b1;
    logic       eoi = 1'b0;
    logic       int_out;
    logic [7:0] vec_out;
    logic       vec_valid;
    logic [7:0] irr_out;
    logic [7:0] isr_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    logic [7:0] exp_q[$];
    logic       vv_seen = 1'b0;

    irq_ack_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_in(req_in), .edge_mode(edge_mode),
        .vec_base(vec_base), .ack_n(ack_n), .eoi(eoi), .int_out(int_out),
        .vec_out(vec_out), .vec_valid(vec_valid), .irr_out(irr_out), .isr_out(isr_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag, input logic [7:0] act,
                         input logic [7:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] vec_of(input int idx);
        return {vec_base, 3'(idx)};
    endfunction

    // driver: queue the expected vector, then run both acknowledge pulses
    task automatic do_ack(input int idx);
        exp_q.push_back(vec_of(idx));
        ack_n = 1'b0; tick();
        check(int_out == 1'b0, "R10 int during ack", {7'd0, int_out}, 8'h00);
        ack_n = 1'b1; tick();
        ack_n = 1'b0; tick();
        ack_n = 1'b1; tick();
    endtask

    task automatic pulse_eoi();
        eoi = 1'b1; tick();
        eoi = 1'b0;
    endtask

    // monitor: pop an expected vector on each start of a valid window
    always @(negedge clk) begin
        if (vec_valid && !vv_seen) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected vector", vec_out, 8'h00);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(vec_out == e, "R7/R8 vector", vec_out, e);
            end
        end
        vv_seen <= vec_valid;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        check(int_out == 0 && vec_valid == 0 && vec_out == 0, "R1 outputs in reset",
              vec_out, 8'h00);
        check(irr_out == 0 && isr_out == 0, "R1 registers in reset", irr_out | isr_out, 8'h00);
        rst_n = 1'b1; tick();
        check(int_out == 0, "R1 int after reset", {7'd0, int_out}, 8'h00);

        // edge request on line 3
        req_in[3] = 1'b1; tick();
        check(irr_out == 8'h08, "R2 edge sets irr", irr_out, 8'h08);
        check(int_out == 1, "R4 int raised", {7'd0, int_out}, 8'h01);
        do_ack(3);
        check(isr_out == 8'h08, "R6 isr set", isr_out, 8'h08);
        check(irr_out == 8'h00, "R6 edge irr cleared", irr_out, 8'h00);
        req_in[3] = 1'b0; tick();

        // second edge on the same line while it is in service
        req_in[3] = 1'b1; tick();
        check(irr_out == 8'h08, "R2 re-edge pending", irr_out, 8'h08);
        check(int_out == 0, "R5 equal priority masked", {7'd0, int_out}, 8'h00);
        req_in[3] = 1'b0; tick();
        check(irr_out == 8'h00, "R2 drop clears irr", irr_out, 8'h00);

        // nested priority: lines 1 and 5 together while 3 in service
        req_in[1] = 1'b1; req_in[5] = 1'b1; tick();
        check(int_out == 1, "R4 higher priority passes", {7'd0, int_out}, 8'h01);
        do_ack(1);
        check(isr_out == 8'h0A, "R6 nested isr", isr_out, 8'h0A);
        check(int_out == 0, "R5 lower priority masked", {7'd0, int_out}, 8'h00);
        pulse_eoi(); tick();
        check(isr_out == 8'h08, "R9 eoi clears line 1 only", isr_out, 8'h08);
        check(int_out == 0, "R5 still masked by 3", {7'd0, int_out}, 8'h00);
        pulse_eoi(); tick();
        check(isr_out == 8'h00, "R9 eoi clears line 3", isr_out, 8'h00);
        check(int_out == 1, "R4 line 5 released", {7'd0, int_out}, 8'h01);
        do_ack(5);
        check(isr_out == 8'h20, "R6 line 5 in service", isr_out, 8'h20);
        pulse_eoi(); tick();
        req_in = '0; tick();

        // withdrawn edge request yields the default vector
        req_in[4] = 1'b1; tick();
        check(int_out == 1, "R4 line 4 pending", {7'd0, int_out}, 8'h01);
        req_in[4] = 1'b0; tick();
        check(int_out == 0 && irr_out == 0, "R2 withdrawn", irr_out, 8'h00);
        do_ack(7);
        check(isr_out == 8'h00, "R8 spurious sets no isr", isr_out, 8'h00);
        check(irr_out[7] == 1'b0, "R8 spurious sets no irr7", irr_out, 8'h00);

        // level-sensed line 6
        req_in[6] = 1'b1; tick();
        check(irr_out == 8'h40, "R3 level follows high", irr_out, 8'h40);
        req_in[6] = 1'b0; tick();
        check(irr_out == 8'h00, "R3 level follows low", irr_out, 8'h00);
        req_in[6] = 1'b1; tick();
        do_ack(6);
        check(isr_out == 8'h40 && irr_out == 8'h40, "R6 level irr kept", irr_out, 8'h40);
        check(int_out == 0, "R5 level masked in service", {7'd0, int_out}, 8'h00);
        pulse_eoi(); tick();
        check(int_out == 1, "R3 level reasserts after eoi", {7'd0, int_out}, 8'h01);
        req_in[6] = 1'b0; tick();
        check(int_out == 0 && irr_out == 0, "R3 level dropped", irr_out, 8'h00);

        // lines 0 (edge) and 7 (level) together
        req_in = 8'h81; tick();
        do_ack(0);
        check(isr_out == 8'h01 && irr_out == 8'h80, "R4 line 0 wins", isr_out, 8'h01);
        pulse_eoi(); tick();
        do_ack(7);
        check(isr_out == 8'h80, "R6 genuine line 7 in service", isr_out, 8'h80);
        pulse_eoi(); tick();
        check(isr_out == 8'h00, "R9 last eoi", isr_out, 8'h00);
        req_in = '0; tick(); tick();

        check(exp_q.size() == 0, "R7 all vectors seen", 8'(exp_q.size()), 8'h00);

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule